// File: doc/BRIEF.md
# Converter Startup and Resync Fade Sequencer

This block shapes the gain envelope of a multichannel audio converter path. After reset is released it keeps the path silent for a fixed number of frame periods, then raises a gain coefficient linearly from zero to unity, one step per frame. The number of frames depends on the sampling-rate mode and on whether the path is playback (DAC) or capture (ADC). When the upstream logic reports a loss of clock synchronization, the block silences the path at once. When sync returns, it waits a much shorter recovery delay and then fades in again. A soft-mute request fades the gain down to zero before the path is muted, and releasing it fades the gain back up.

The frame clock arrives as a one-cycle tick in the system clock domain. The block never multiplies samples: it delivers the gain coefficient (unity equals 2^13) and a mute flag to the datapath.

The states are named as follows:

- HOLD: waiting out the start delay.
- FADE_IN: the gain ramps up.
- RUN: the gain is at unity.
- FADE_OUT: the gain ramps down.
- MUTED: the soft mute has completed.
- LOST: sync is absent.
- RESYNC: waiting out the recovery delay.
- ERROR: the configuration is unsupported.

The transitions are as follows:

- HOLD→FADE_IN and RESYNC→FADE_IN when the delay completes.
- FADE_IN→RUN when unity is reached.
- RUN→FADE_OUT and FADE_IN→FADE_OUT on soft mute.
- FADE_OUT→FADE_IN and MUTED→FADE_IN on release of soft mute.
- FADE_OUT→MUTED when zero is reached.
- Any state except ERROR→LOST on sync loss.
- LOST→RESYNC when sync returns.
- Any state→ERROR on a bad configuration.

Top module: `conv_fade_seq`

## Requirements
- R1: While reset is asserted the block is in HOLD with mute=1, gain=0 and cfg_err=0.
- R2: On the DAC path (path_adc=0), mute stays 1 through the first N-1 frame ticks after reset release and falls with the N-th tick, with gain 0. N is 3600, 7200 or 14400 for rate_sel 0 (single), 1 (dual) or 2 (quad).
- R3: On the ADC path (path_adc=1), the same start rule applies with N = 4800 for rate_sel 0 and N = 9600 for rate_sel 1.
- R4: During a fade-in, each frame tick raises the gain by 8192/L. After L ticks the gain equals unity (8192). L is 2048, 4096 or 8192 for single, dual or quad rate on either path.
- R5: Clock cycles without a frame tick change neither the gain nor the delay count.
- R6: One cycle after any clock edge at which sync_lost is high, mute=1 and gain=0. Both hold while sync_lost stays high, whatever the frame ticks do.
- R7: After sync_lost falls, mute stays 1 for R-1 ticks and falls with the R-th tick, with the gain restarting from 0. R is 38, 38 or 29 for DAC single, dual or quad, and 60 for ADC single or dual.
- R8: With soft_mute high, each tick lowers the gain by 8192/L from its current value. When the gain reaches 0, mute rises. With soft_mute low, the gain ramps back up by the same step per tick.
- R9: ADC with quad rate, or rate_sel 3 on either path, sets cfg_err=1, mute=1 and gain=0 from the next cycle. The error stays until reset, even if the configuration is corrected.
- R10: The gain never exceeds 8192, and it is 0 whenever mute is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (internal reset release) |
| frame_tick | input | 1 | One-cycle pulse per frame-clock period |
| rate_sel | input | 2 | 0 single, 1 dual, 2 quad, 3 reserved |
| path_adc | input | 1 | 0 playback (DAC) timings, 1 capture (ADC) timings |
| sync_lost | input | 1 | High while clock synchronization is absent |
| soft_mute | input | 1 | Request to fade out and mute |
| gain | output | 14 | Gain coefficient, unity = 8192 |
| mute | output | 1 | High while the path must be silent |
| cfg_err | output | 1 | Unsupported rate/path combination |

## Verification
Every result is registered and is due one clock after the edge that samples its stimulus. A delay or fade completes on the edge that samples the last required tick. Mute and gain react to sync_lost, soft_mute or a bad configuration on the first edge that sees them.

The bench changes inputs on falling edges and reads outputs on the following falling edge, so each check sits one register after its cause. It counts the ticks it drives, including random idle gaps between ticks, and checks just before and just after each delay boundary. After every soft_mute or sync_lost change it leaves one or two idle cycles before ticking, so the state change and the ramp steps are never expected on the same edge.

// File: rtl/conv_fade_pkg.sv
package conv_fade_pkg;

    localparam int FS_CNT_W     = 16;
    localparam int FS_GAIN_FRAC = 13;
    localparam int FS_GAIN_W    = FS_GAIN_FRAC + 1;
    localparam int FS_UNITY     = 1 << FS_GAIN_FRAC;

    typedef enum logic [1:0] {
        RATE_SINGLE = 2'd0,
        RATE_DUAL   = 2'd1,
        RATE_QUAD   = 2'd2,
        RATE_RSVD   = 2'd3
    } rate_e;

    typedef enum logic [2:0] {
        ST_HOLD,
        ST_FADE_IN,
        ST_RUN,
        ST_FADE_OUT,
        ST_MUTED,
        ST_LOST,
        ST_RESYNC,
        ST_ERROR
    } seq_state_e;

    typedef struct packed {
        logic [FS_CNT_W-1:0]  start_len;
        logic [FS_CNT_W-1:0]  resync_len;
        logic [FS_GAIN_W-1:0] step;
        logic                 bad;
    } fade_cfg_t;

endpackage

// File: rtl/conv_fade_cfg.sv
module conv_fade_cfg
    import conv_fade_pkg::*;
#(
    parameter int DAC_START_S  = 3600,
    parameter int DAC_START_D  = 7200,
    parameter int DAC_START_Q  = 14400,
    parameter int ADC_START_S  = 4800,
    parameter int ADC_START_D  = 9600,
    parameter int FADE_S       = 2048,
    parameter int FADE_D       = 4096,
    parameter int FADE_Q       = 8192,
    parameter int DAC_RESYNC_S = 38,
    parameter int DAC_RESYNC_D = 38,
    parameter int DAC_RESYNC_Q = 29,
    parameter int ADC_RESYNC_S = 60,
    parameter int ADC_RESYNC_D = 60
) (
    input  logic [1:0] rate_sel,
    input  logic       path_adc,
    output fade_cfg_t  cfg
);

    localparam int STEP_S = FS_UNITY / FADE_S;
    localparam int STEP_D = FS_UNITY / FADE_D;
    localparam int STEP_Q = FS_UNITY / FADE_Q;

    always_comb begin
        cfg = '0;
        if (path_adc) begin
            unique case (rate_e'(rate_sel))
                RATE_SINGLE: begin
                    cfg.start_len  = FS_CNT_W'(ADC_START_S);
                    cfg.resync_len = FS_CNT_W'(ADC_RESYNC_S);
                    cfg.step       = FS_GAIN_W'(STEP_S);
                end
                RATE_DUAL: begin
                    cfg.start_len  = FS_CNT_W'(ADC_START_D);
                    cfg.resync_len = FS_CNT_W'(ADC_RESYNC_D);
                    cfg.step       = FS_GAIN_W'(STEP_D);
                end
                RATE_QUAD, RATE_RSVD: cfg.bad = 1'b1;
            endcase
        end else begin
            unique case (rate_e'(rate_sel))
                RATE_SINGLE: begin
                    cfg.start_len  = FS_CNT_W'(DAC_START_S);
                    cfg.resync_len = FS_CNT_W'(DAC_RESYNC_S);
                    cfg.step       = FS_GAIN_W'(STEP_S);
                end
                RATE_DUAL: begin
                    cfg.start_len  = FS_CNT_W'(DAC_START_D);
                    cfg.resync_len = FS_CNT_W'(DAC_RESYNC_D);
                    cfg.step       = FS_GAIN_W'(STEP_D);
                end
                RATE_QUAD: begin
                    cfg.start_len  = FS_CNT_W'(DAC_START_Q);
                    cfg.resync_len = FS_CNT_W'(DAC_RESYNC_Q);
                    cfg.step       = FS_GAIN_W'(STEP_Q);
                end
                RATE_RSVD: cfg.bad = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/conv_fade_cnt.sv
module conv_fade_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] limit,
    output logic         done
);

    logic [W-1:0] cnt;

    assign done = en && (cnt == limit - W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= cnt + W'(1);
        end
    end

    // R5: the delay count only moves on a counted tick
    a_r5_cnt_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(cnt));

endmodule

// File: rtl/conv_fade_ramp.sv
module conv_fade_ramp #(
    parameter int GW    = 14,
    parameter int UNITY = 8192
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          zero,
    input  logic          up,
    input  logic          down,
    input  logic [GW-1:0] step,
    output logic [GW-1:0] gain,
    output logic          top_next,
    output logic          zero_next,
    output logic          at_zero
);

    localparam logic [GW:0] UNITY_V = (GW+1)'(UNITY);

    logic [GW:0] sum;

    assign sum       = {1'b0, gain} + {1'b0, step};
    assign top_next  = (sum >= UNITY_V);
    assign zero_next = (gain <= step);
    assign at_zero   = (gain == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gain <= '0;
        end else if (zero) begin
            gain <= '0;
        end else if (up) begin
            gain <= top_next ? UNITY_V[GW-1:0] : sum[GW-1:0];
        end else if (down) begin
            gain <= zero_next ? '0 : gain - step;
        end
    end

    // R10: the coefficient never passes unity
    a_r10_gain_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, gain} <= UNITY_V);

    // R4: an up step never lowers the gain
    a_r4_up_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        (up && !zero) |=> (gain >= $past(gain)));

endmodule

// File: rtl/conv_fade_seq.sv
module conv_fade_seq
    import conv_fade_pkg::*;
#(
    parameter int DAC_START_S  = 3600,
    parameter int DAC_START_D  = 7200,
    parameter int DAC_START_Q  = 14400,
    parameter int ADC_START_S  = 4800,
    parameter int ADC_START_D  = 9600,
    parameter int FADE_S       = 2048,
    parameter int FADE_D       = 4096,
    parameter int FADE_Q       = 8192,
    parameter int DAC_RESYNC_S = 38,
    parameter int DAC_RESYNC_D = 38,
    parameter int DAC_RESYNC_Q = 29,
    parameter int ADC_RESYNC_S = 60,
    parameter int ADC_RESYNC_D = 60
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_tick,
    input  logic [1:0]           rate_sel,
    input  logic                 path_adc,
    input  logic                 sync_lost,
    input  logic                 soft_mute,
    output logic [FS_GAIN_W-1:0] gain,
    output logic                 mute,
    output logic                 cfg_err
);

    fade_cfg_t           cfg;
    seq_state_e          st, nxt;
    logic                cnt_clr, cnt_en, cnt_done;
    logic [FS_CNT_W-1:0] cnt_limit;
    logic                g_zero, g_up, g_dn;
    logic                top_next, zero_next, at_zero;

    conv_fade_cfg #(
        .DAC_START_S (DAC_START_S),  .DAC_START_D (DAC_START_D),
        .DAC_START_Q (DAC_START_Q),  .ADC_START_S (ADC_START_S),
        .ADC_START_D (ADC_START_D),  .FADE_S      (FADE_S),
        .FADE_D      (FADE_D),       .FADE_Q      (FADE_Q),
        .DAC_RESYNC_S(DAC_RESYNC_S), .DAC_RESYNC_D(DAC_RESYNC_D),
        .DAC_RESYNC_Q(DAC_RESYNC_Q), .ADC_RESYNC_S(ADC_RESYNC_S),
        .ADC_RESYNC_D(ADC_RESYNC_D)
    ) cfg_i (
        .rate_sel(rate_sel),
        .path_adc(path_adc),
        .cfg     (cfg)
    );

    assign cnt_limit = (st == ST_RESYNC) ? cfg.resync_len : cfg.start_len;

    conv_fade_cnt #(.W(FS_CNT_W)) cnt_i (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (cnt_clr),
        .en   (cnt_en),
        .limit(cnt_limit),
        .done (cnt_done)
    );

    conv_fade_ramp #(.GW(FS_GAIN_W), .UNITY(FS_UNITY)) ramp_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .zero     (g_zero),
        .up       (g_up),
        .down     (g_dn),
        .step     (cfg.step),
        .gain     (gain),
        .top_next (top_next),
        .zero_next(zero_next),
        .at_zero  (at_zero)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_HOLD;
        else        st <= nxt;
    end

    // next state and datapath controls
    always_comb begin
        nxt     = st;
        cnt_clr = 1'b0;
        cnt_en  = 1'b0;
        g_zero  = 1'b0;
        g_up    = 1'b0;
        g_dn    = 1'b0;
        if (cfg.bad) begin
            nxt    = ST_ERROR;
            g_zero = 1'b1;
        end else begin
            unique case (st)
                ST_HOLD, ST_RESYNC: begin
                    if (sync_lost) begin
                        nxt     = ST_LOST;
                        cnt_clr = 1'b1;
                        g_zero  = 1'b1;
                    end else if (frame_tick) begin
                        cnt_en = 1'b1;
                        if (cnt_done) begin
                            nxt     = ST_FADE_IN;
                            cnt_clr = 1'b1;
                        end
                    end
                end
                ST_FADE_IN: begin
                    if (sync_lost) begin
                        nxt    = ST_LOST;
                        g_zero = 1'b1;
                    end else if (soft_mute) begin
                        nxt = ST_FADE_OUT;
                    end else if (frame_tick) begin
                        g_up = 1'b1;
                        if (top_next) nxt = ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (sync_lost) begin
                        nxt    = ST_LOST;
                        g_zero = 1'b1;
                    end else if (soft_mute) begin
                        nxt = ST_FADE_OUT;
                    end
                end
                ST_FADE_OUT: begin
                    if (sync_lost) begin
                        nxt    = ST_LOST;
                        g_zero = 1'b1;
                    end else if (!soft_mute) begin
                        nxt = ST_FADE_IN;
                    end else if (at_zero) begin
                        nxt = ST_MUTED;
                    end else if (frame_tick) begin
                        g_dn = 1'b1;
                        if (zero_next) nxt = ST_MUTED;
                    end
                end
                ST_MUTED: begin
                    if (sync_lost) begin
                        nxt    = ST_LOST;
                        g_zero = 1'b1;
                    end else if (!soft_mute) begin
                        nxt = ST_FADE_IN;
                    end
                end
                ST_LOST: begin
                    g_zero = 1'b1;
                    if (!sync_lost) begin
                        nxt     = ST_RESYNC;
                        cnt_clr = 1'b1;
                    end
                end
                ST_ERROR: begin
                    g_zero = 1'b1;
                end
            endcase
        end
    end

    // outputs decoded from the state register
    always_comb begin
        mute    = 1'b0;
        cfg_err = 1'b0;
        unique case (st)
            ST_HOLD, ST_MUTED, ST_LOST, ST_RESYNC: mute = 1'b1;
            ST_ERROR: begin
                mute    = 1'b1;
                cfg_err = 1'b1;
            end
            ST_FADE_IN, ST_RUN, ST_FADE_OUT: mute = 1'b0;
        endcase
    end

    // R6: a sampled sync loss silences the path on the next cycle
    a_r6_lost_silences: assert property (@(posedge clk) disable iff (!rst_n)
        sync_lost |=> (mute && gain == '0));

    // R9: an error always comes with silence
    a_r9_err_silent: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (mute && gain == '0));

    // R9: the error is sticky until reset
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    // R10: muted implies zero gain
    a_r10_mute_zero_gain: assert property (@(posedge clk) disable iff (!rst_n)
        mute |-> (gain == '0));

    // R5: no tick, no sync loss, no error -> gain unchanged
    a_r5_gain_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_tick && !sync_lost && !cfg.bad) |=> $stable(gain));

endmodule

// File: tb/conv_fade_seq_tb_top.sv
`timescale 1ns/1ps
module conv_fade_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_tick = 1'b0;
    logic [1:0]  rate_sel = 2'd0;
    logic        path_adc = 1'b0;
    logic        sync_lost = 1'b0;
    logic        soft_mute = 1'b0;
    logic [13:0] gain;
    logic        mute;
    logic        cfg_err;

    int n_total = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    localparam int UNITY = 8192;

    always #2 clk = ~clk;

    conv_fade_seq dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_tick(frame_tick),
        .rate_sel  (rate_sel),
        .path_adc  (path_adc),
        .sync_lost (sync_lost),
        .soft_mute (soft_mute),
        .gain      (gain),
        .mute      (mute),
        .cfg_err   (cfg_err)
    );

    function automatic int f_start(input bit adc, input int rate);
        if (adc) return (rate == 0) ? 4800 : 9600;
        return (rate == 0) ? 3600 : (rate == 1) ? 7200 : 14400;
    endfunction

    function automatic int f_fade(input int rate);
        return (rate == 0) ? 2048 : (rate == 1) ? 4096 : 8192;
    endfunction

    function automatic int f_resync(input bit adc, input int rate);
        if (adc) return 60;
        return (rate == 2) ? 29 : 38;
    endfunction

    function automatic int f_step(input int rate);
        return UNITY / f_fade(rate);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_total++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic ticks(input int n, input bit gappy);
        for (int i = 0; i < n; i++) begin
            frame_tick = 1'b1;
            @(negedge clk);
            if (gappy) begin
                int g;
                g = $urandom_range(0, 3);
                if (g != 0) begin
                    frame_tick = 1'b0;
                    repeat (g) @(negedge clk);
                end
            end
        end
        frame_tick = 1'b0;
    endtask

    task automatic do_reset(input bit adc, input logic [1:0] rate);
        @(negedge clk);
        rst_n     = 1'b0;
        sync_lost = 1'b0;
        soft_mute = 1'b0;
        frame_tick = 1'b0;
        path_adc  = adc;
        rate_sel  = rate;
        repeat (3) @(negedge clk);
        check("R1 reset mute", int'(mute), 1);
        check("R1 reset gain", int'(gain), 0);
        check("R1 reset err", int'(cfg_err), 0);
        rst_n = 1'b1;
    endtask

    task automatic run_cfg(input bit adc, input int rate);
        int st, fd, rs, sp, q;
        string rq;
        st = f_start(adc, rate);
        fd = f_fade(rate);
        rs = f_resync(adc, rate);
        sp = f_step(rate);
        rq = adc ? "R3 start delay" : "R2 start delay";
        do_reset(adc, 2'(rate));
        ticks(st - 1, 1'b0);
        check(rq, int'(mute), 1);
        ticks(1, 1'b0);
        check(rq, int'(mute), 0);
        check("R4 gain at fade start", int'(gain), 0);
        q = fd / 4;
        ticks(q, 1'b1);
        check("R4 quarter fade", int'(gain), q * sp);
        frame_tick = 1'b0;
        repeat (3) @(negedge clk);
        check("R5 idle keeps gain", int'(gain), q * sp);
        ticks(fd - q, 1'b0);
        check("R4 unity after fade", int'(gain), UNITY);
        check("R4 unmuted in run", int'(mute), 0);
        sync_lost = 1'b1;
        @(negedge clk);
        check("R6 lost mute", int'(mute), 1);
        check("R6 lost gain", int'(gain), 0);
        ticks(50, 1'b0);
        check("R6 ticks ignored while lost", int'(mute), 1);
        sync_lost = 1'b0;
        @(negedge clk);
        ticks(rs - 1, 1'b0);
        check("R7 resync still muted", int'(mute), 1);
        ticks(1, 1'b0);
        check("R7 resync unmuted", int'(mute), 0);
        check("R7 resync gain restarts", int'(gain), 0);
        ticks(fd, 1'b0);
        check("R4 unity after resync fade", int'(gain), UNITY);
    endtask

    initial begin
        int seed_init;
        int g_exp;
        seed_init = $urandom(32'h5eed);
        // DAC single with soft-mute sweeps
        run_cfg(1'b0, 0);
        soft_mute = 1'b1;
        repeat (2) @(negedge clk);
        ticks(1000, 1'b0);
        check("R8 fade out step", int'(gain), UNITY - 4000);
        check("R8 not muted mid fade", int'(mute), 0);
        soft_mute = 1'b0;
        repeat (2) @(negedge clk);
        ticks(10, 1'b0);
        check("R8 fade back up", int'(gain), UNITY - 4000 + 40);
        soft_mute = 1'b1;
        repeat (2) @(negedge clk);
        ticks((UNITY - 3960) / 4, 1'b0);
        @(negedge clk);
        check("R8 muted after fade out", int'(mute), 1);
        check("R8 zero after fade out", int'(gain), 0);
        // random soft-mute walk, DAC single step 4
        g_exp = 0;
        for (int it = 0; it < 24; it++) begin
            bit on;
            int n;
            on = 1'($urandom_range(0, 1));
            n  = $urandom_range(0, 400);
            soft_mute = on;
            repeat (2) @(negedge clk);
            ticks(n, 1'b0);
            if (on) g_exp = (g_exp - 4 * n < 0) ? 0 : g_exp - 4 * n;
            else    g_exp = (g_exp + 4 * n > UNITY) ? UNITY : g_exp + 4 * n;
            check("R8 random walk gain", int'(gain), g_exp);
            check("R8 random walk mute", int'(mute), int'(on && g_exp == 0));
        end
        soft_mute = 1'b0;
        run_cfg(1'b0, 1);
        run_cfg(1'b0, 2);
        run_cfg(1'b1, 0);
        run_cfg(1'b1, 1);
        // unsupported configurations
        do_reset(1'b1, 2'd2);
        repeat (2) @(negedge clk);
        check("R9 adc quad err", int'(cfg_err), 1);
        check("R9 adc quad mute", int'(mute), 1);
        ticks(100, 1'b1);
        check("R9 err gain", int'(gain), 0);
        rate_sel = 2'd0;
        ticks(5000, 1'b0);
        check("R9 err sticky after fix", int'(cfg_err), 1);
        check("R9 still muted after fix", int'(mute), 1);
        do_reset(1'b0, 2'd3);
        repeat (2) @(negedge clk);
        check("R9 reserved rate err", int'(cfg_err), 1);
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_total++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

endmodule